// File: doc/BRIEF.md
# Three-tap oscillator collapse timer

This block times how long a three-stage collision ring oscillator keeps its fast oscillation, and it does this without using the oscillator as a clock. For each oscillator channel, the three tap signals go into an all-equal gate. That gate drives the asynchronous set of a detector flop whose data input is tied to zero. While the fast oscillation lasts, the taps pass through an all-equal state at least twice in every system clock period. The flop is therefore set again between clock edges, whatever the phase between the oscillator and the system clock. Once the fast oscillation collapses to a single travelling edge, the taps are never all equal. The next system clock edge then clears the flop, and it stays cleared.

A single counter in the system clock domain is shared by every channel. Each channel has its own detector, a two-flop synchronizer, and a result slot. The slot stores the counter value, corrected for the synchronizer latency, on the first period in which its detector reads low. A control state machine steps through IDLE, ARMED, RUNNING and DONE, and it enables the oscillators for the measurement window. When all channels have finished, the results are published together with a one-cycle valid strobe. Bit 0 of each result is the raw random output. If a channel is still oscillating fast when the programmable limit is reached, its result saturates and its timeout flag is set, so health monitoring can see it.

The state machine has four transitions:
- IDLE to ARMED on `start_i`.
- ARMED to RUNNING unconditionally, after one cycle with the oscillators enabled.
- RUNNING to DONE when every channel has finished.
- DONE to IDLE unconditionally.

Top module: `osc_collapse_timer`

## Requirements
- R1: While reset is asserted and after it is released, `osc_en_o`, `valid_o`, every `count_o` field, `rnd_o` and `timeout_o` are all zero.
- R2: A `start_i` accepted in IDLE raises `osc_en_o` on the next cycle (ARMED) before counting begins. `osc_en_o` stays high in the following RUNNING cycles.
- R3: A channel's result equals the number of whole system clock periods, counted from the edge that enters RUNNING, in which its three taps were all equal (000 or 111) at least once. Counting ends at the first period with no all-equal instant.
- R4: All channels share one counter but keep independent results. The result for channel c sits in `count_o[c*CNT_W +: CNT_W]`. DONE is entered only after the last channel has finished.
- R5: If a channel's fast oscillation lasts more than `timeout_lim_i` periods, its result is all ones and its `timeout_o` bit is 1. If it lasts `timeout_lim_i` periods or fewer, the plain value is reported and the flag is 0.
- R6: `valid_o` is high for exactly one cycle, after edge max(m_c) + SYNC_STAGES + 1 counted from the RUNNING entry edge. Here m_c is the channel's period count, capped at `timeout_lim_i`. `osc_en_o` is low while `valid_o` is high and in the following idle cycles.
- R7: `rnd_o[c]` equals bit 0 of channel c's published result.
- R8: A `start_i` seen in ARMED, RUNNING or DONE has no effect: the measurement finishes on schedule and no new measurement begins.
- R9: `count_o` and `timeout_o` change only in the cycle where `valid_o` is high. They hold their values through idle time and through the next measurement until its own `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only in IDLE |
| tap_i | input | 3*N_CH | Three oscillator taps per channel, asynchronous to clk |
| timeout_lim_i | input | CNT_W | Largest period count reported before saturation |
| osc_en_o | output | 1 | Oscillator enable, high in ARMED and RUNNING |
| valid_o | output | 1 | One-cycle strobe when the published results are new |
| count_o | output | N_CH*CNT_W | Published period count per channel |
| rnd_o | output | N_CH | Raw random bit per channel (result bit 0) |
| timeout_o | output | N_CH | Per-channel saturation flag |

## Verification
The bench builds the block with two channels, an 8-bit count and two synchronizer stages. Two channels show that one shared counter serves oscillators that collapse at different times, and that DONE waits for the slower channel. The 8-bit limit allows both zero and full-scale limits, and with them saturation at small counts and the exact boundary where the period count equals the limit. Two synchronizer stages fix the valid strobe at three edges after the last fast period, so the bench can predict the cycle of the latency correction exactly.

// File: rtl/osc_timer_pkg.sv
`timescale 1ns/1ps
package osc_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_RUNNING = 2'd2,
        ST_DONE    = 2'd3
    } tmr_state_e;

    // True when all three taps carry the same level.
    function automatic logic taps_agree(input logic [2:0] taps);
        return (&taps) | ~(|taps);
    endfunction

endpackage

// File: rtl/osc_tap_detector.sv
module osc_tap_detector #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] tap_i,
    input  logic       hold_i,
    output logic       alive_o
);

    logic                   tap_eq;
    logic                   det_q;
    logic [SYNC_STAGES-1:0] sync_q;

    assign tap_eq = osc_timer_pkg::taps_agree(tap_i);

    // Data input is a constant zero; every all-equal pulse between two
    // clock edges sets the flop again, so it only reads low once a whole
    // period has passed without one.
    always_ff @(posedge clk or posedge tap_eq) begin
        if (tap_eq) begin
            det_q <= 1'b1;
        end else begin
            det_q <= 1'b0;
        end
    end

    // Outside a measurement the chain is filled with ones so that stale
    // samples never look like a collapse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else if (hold_i) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], det_q};
        end
    end

    assign alive_o = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/osc_time_counter.sv
module osc_time_counter #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          run_i,
    output logic [CW-1:0] cnt_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (run_i && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/osc_result_slot.sv
module osc_result_slot #(
    parameter int CNT_W = 8,
    parameter int LAT   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             run_i,
    input  logic             alive_i,
    input  logic [CNT_W:0]   cnt_i,
    input  logic [CNT_W-1:0] lim_i,
    input  logic             publish_i,
    output logic             fin_o,
    output logic [CNT_W-1:0] count_o,
    output logic             tout_o
);

    localparam int            CW    = CNT_W + 1;
    localparam logic [CW-1:0] LAT_V = CW'(LAT);

    logic [CW-1:0]    meas;
    logic             past_lat;
    logic             at_limit;
    logic             finishing;
    logic             done_q;
    logic [CNT_W-1:0] cap_q;
    logic [CNT_W-1:0] cap_d;
    logic             ctout_q;
    logic             ctout_d;
    logic [CNT_W-1:0] pub_q;
    logic             ptout_q;

    // The detector reading seen now is LAT cycles old.
    assign meas      = cnt_i - LAT_V;
    assign past_lat  = (cnt_i >= LAT_V);
    assign at_limit  = past_lat && (meas == {1'b0, lim_i});
    assign finishing = run_i && !done_q && (!alive_i || at_limit);

    always_comb begin
        cap_d   = cap_q;
        ctout_d = ctout_q;
        if (finishing) begin
            if (!alive_i) begin
                cap_d   = meas[CNT_W-1:0];
                ctout_d = 1'b0;
            end else begin
                cap_d   = '1;
                ctout_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            cap_q   <= '0;
            ctout_q <= 1'b0;
        end else begin
            cap_q   <= cap_d;
            ctout_q <= ctout_d;
            if (arm_i) begin
                done_q <= 1'b0;
            end else if (finishing) begin
                done_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pub_q   <= '0;
            ptout_q <= 1'b0;
        end else if (publish_i) begin
            pub_q   <= cap_d;
            ptout_q <= ctout_d;
        end
    end

    assign fin_o   = done_q | finishing;
    assign count_o = pub_q;
    assign tout_o  = ptout_q;

endmodule

// File: rtl/osc_collapse_timer.sv
module osc_collapse_timer
    import osc_timer_pkg::*;
#(
    parameter int N_CH        = 2,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [3*N_CH-1:0]     tap_i,
    input  logic [CNT_W-1:0]      timeout_lim_i,
    output logic                  osc_en_o,
    output logic                  valid_o,
    output logic [N_CH*CNT_W-1:0] count_o,
    output logic [N_CH-1:0]       rnd_o,
    output logic [N_CH-1:0]       timeout_o
);

    localparam int CW = CNT_W + 1;

    tmr_state_e      state_q;
    tmr_state_e      state_d;
    logic [CW-1:0]   cnt_q;
    logic [N_CH-1:0] alive;
    logic [N_CH-1:0] fin;
    logic            all_fin;
    logic            clr_cnt;
    logic            run_cnt;
    logic            hold_sync;
    logic            arm_slots;
    logic            publish;

    assign all_fin = &fin;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_ARMED;
            ST_ARMED:   state_d = ST_RUNNING;
            ST_RUNNING: if (all_fin) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        osc_en_o  = 1'b0;
        valid_o   = 1'b0;
        clr_cnt   = 1'b0;
        run_cnt   = 1'b0;
        hold_sync = 1'b1;
        arm_slots = 1'b0;
        publish   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ARMED: begin
                osc_en_o  = 1'b1;
                clr_cnt   = 1'b1;
                arm_slots = 1'b1;
            end
            ST_RUNNING: begin
                osc_en_o  = 1'b1;
                run_cnt   = 1'b1;
                hold_sync = 1'b0;
                publish   = all_fin;
            end
            ST_DONE: begin
                valid_o = 1'b1;
            end
            default: begin
            end
        endcase
    end

    osc_time_counter #(.CW(CW)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clr_cnt),
        .run_i   (run_cnt),
        .cnt_o   (cnt_q)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        osc_tap_detector #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .tap_i   (tap_i[3*g +: 3]),
            .hold_i  (hold_sync),
            .alive_o (alive[g])
        );

        osc_result_slot #(.CNT_W(CNT_W), .LAT(SYNC_STAGES)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .arm_i     (arm_slots),
            .run_i     (run_cnt),
            .alive_i   (alive[g]),
            .cnt_i     (cnt_q),
            .lim_i     (timeout_lim_i),
            .publish_i (publish),
            .fin_o     (fin[g]),
            .count_o   (count_o[g*CNT_W +: CNT_W]),
            .tout_o    (timeout_o[g])
        );

        assign rnd_o[g] = count_o[g*CNT_W];
    end

endmodule

// File: rtl/osc_collapse_timer_chk.sv
module osc_collapse_timer_chk
    import osc_timer_pkg::*;
#(
    parameter int N_CH  = 2,
    parameter int CNT_W = 8,
    parameter int LAT   = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_i,
    input logic                  osc_en_o,
    input logic                  valid_o,
    input logic [N_CH*CNT_W-1:0] count_o,
    input logic [N_CH-1:0]       timeout_o,
    input logic [CNT_W-1:0]      lim_i,
    input tmr_state_e            state_q,
    input logic [CNT_W:0]        cnt_q
);

    localparam logic [CNT_W:0] LAT_V = (CNT_W+1)'(LAT);

    AST_ARMED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en_o) |-> state_q == ST_ARMED); // R2

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R6

    AST_OSC_OFF_AT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !osc_en_o); // R6

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start_i) |=> state_q != ST_ARMED); // R8

    AST_HELD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(count_o) && $stable(timeout_o))); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUNNING |-> cnt_q <= ({1'b0, lim_i} + LAT_V)); // R5

    for (genvar c = 0; c < N_CH; c++) begin : g_chk
        AST_TOUT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_o && timeout_o[c]) |-> count_o[c*CNT_W +: CNT_W] == '1); // R5

        AST_VALUE_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_o && !timeout_o[c]) |-> count_o[c*CNT_W +: CNT_W] <= lim_i); // R3
    end

endmodule

bind osc_collapse_timer osc_collapse_timer_chk #(
    .N_CH  (N_CH),
    .CNT_W (CNT_W),
    .LAT   (SYNC_STAGES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .osc_en_o  (osc_en_o),
    .valid_o   (valid_o),
    .count_o   (count_o),
    .timeout_o (timeout_o),
    .lim_i     (timeout_lim_i),
    .state_q   (state_q),
    .cnt_q     (cnt_q)
);

// File: tb/tb_osc_collapse_timer.sv
module tb_osc_collapse_timer;

    localparam int N_CH  = 2;
    localparam int CNT_W = 8;
    localparam int SYNC  = 2;

    // Columns: fast periods ch0, fast periods ch1, limit,
    //          cycle of a spurious start (-1 none), expected ch0, expected ch1
    localparam int VEC [8][6] = '{
        '{ 5,  9,  40, -1,   5,   9},
        '{ 0,  1,  40, -1,   0,   1},
        '{30, 12,  20,  6, 255,  12},
        '{20, 20,  20, -1,  20,  20},
        '{21,  3,  20,  2, 255,   3},
        '{ 0,  1,   0, -1,   0, 255},
        '{ 2,  7, 255,  4,   2,   7},
        '{ 1,  0,   5,  0,   1,   0}
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  start = 1'b0;
    logic [2:0]            tap0 = 3'b101;
    logic [2:0]            tap1 = 3'b101;
    logic [CNT_W-1:0]      lim = '0;
    logic                  osc_en;
    logic                  valid;
    logic [N_CH*CNT_W-1:0] cnt_out;
    logic [N_CH-1:0]       rnd;
    logic [N_CH-1:0]       tout;
    logic [N_CH*CNT_W-1:0] prev_cnt = '0;
    bit                    stop_taps = 1'b0;
    int                    checks = 0;
    int                    fails = 0;

    always #5 clk = ~clk;

    osc_collapse_timer #(.N_CH(N_CH), .CNT_W(CNT_W), .SYNC_STAGES(SYNC)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .tap_i         ({tap1, tap0}),
        .timeout_lim_i (lim),
        .osc_en_o      (osc_en),
        .valid_o       (valid),
        .count_o       (cnt_out),
        .rnd_o         (rnd),
        .timeout_o     (tout)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Tap pattern at step j (0.5 ns steps, offset 0.25 ns from the RUNNING entry edge).
    function automatic logic [2:0] wave(input int j, input int f);
        int s;
        if (j < 20*f - 2) begin
            case (j % 6)
                0: return 3'b000;
                1: return 3'b100;
                2: return 3'b110;
                3: return 3'b111;
                4: return 3'b011;
                default: return 3'b001;
            endcase
        end
        s = (j - (20*f - 2)) / 14;
        case (s % 6)
            0: return 3'b100;
            1: return 3'b110;
            2: return 3'b010;
            3: return 3'b011;
            4: return 3'b001;
            default: return 3'b101;
        endcase
    endfunction

    task automatic drive_taps(input int f0, input int f1);
        int j;
        @(posedge clk);
        #0.25;
        j = 0;
        while (!stop_taps) begin
            tap0 = wave(j, f0);
            tap1 = wave(j, f1);
            #0.5;
            j++;
        end
        tap0 = 3'b101;
        tap1 = 3'b101;
    endtask

    function automatic int fin_edge(input int f, input int lv);
        return ((f > lv) ? lv : f) + SYNC + 1;
    endfunction

    task automatic run_meas(input int f0, input int f1, input int lv, input int spur,
                            input int e0, input int e1);
        int kexp;
        int k;
        bit got;
        int fs[2];
        int es[2];
        logic [N_CH*CNT_W-1:0] exp_cnt;
        fs[0] = f0; fs[1] = f1; es[0] = e0; es[1] = e1;
        kexp = (fin_edge(f0, lv) > fin_edge(f1, lv)) ? fin_edge(f0, lv) : fin_edge(f1, lv);
        exp_cnt = {CNT_W'(e1), CNT_W'(e0)};
        lim = CNT_W'(lv);
        stop_taps = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        fork
            drive_taps(f0, f1);
        join_none
        #1 start = 1'b0;
        @(negedge clk);
        check(osc_en && !valid, "R2 enable raised in ARMED", int'(osc_en), 1);
        if (spur == 0) start = 1'b1;
        @(posedge clk);
        k = 0;
        got = 1'b0;
        while (!got && k < 400) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            start = (k == spur);
            if (k == 1) begin
                check(osc_en == 1'b1, "R2 enable held in RUNNING", int'(osc_en), 1);
                check(cnt_out == prev_cnt, "R9 results held during run", int'(cnt_out), int'(prev_cnt));
            end
            if (valid) got = 1'b1;
        end
        check(got && k == kexp, "R6 R4 valid cycle", k, kexp);
        check(!osc_en, "R6 enable low at valid", int'(osc_en), 0);
        for (int c = 0; c < N_CH; c++) begin
            bit expt;
            int act;
            expt = fs[c] > lv;
            act  = int'(cnt_out[c*CNT_W +: CNT_W]);
            if (expt) check(act == es[c], "R5 saturated count", act, es[c]);
            else      check(act == es[c], "R3 R4 channel count", act, es[c]);
            check(tout[c] == expt, "R5 timeout flag", int'(tout[c]), int'(expt));
            check(rnd[c] == es[c][0], "R7 random bit", int'(rnd[c]), es[c] & 1);
        end
        stop_taps = 1'b1;
        @(negedge clk);
        check(!valid, "R6 single strobe", int'(valid), 0);
        check(!osc_en, "R8 no rearm after run", int'(osc_en), 0);
        repeat (3) @(negedge clk);
        check(cnt_out == exp_cnt && !osc_en && !valid, "R9 R8 idle hold", int'(cnt_out), int'(exp_cnt));
        prev_cnt = exp_cnt;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R6 watchdog actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(!osc_en && !valid && cnt_out == '0 && rnd == '0 && tout == '0,
              "R1 outputs in reset", int'(cnt_out), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!osc_en && !valid && cnt_out == '0 && tout == '0,
              "R1 outputs after reset", int'(osc_en), 0);

        for (int i = 0; i < 8; i++) begin
            run_meas(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5]);
        end

        // Reset in the middle of a measurement.
        lim = 8'd100;
        stop_taps = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        fork
            drive_taps(50, 50);
        join_none
        #1 start = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(!osc_en && !valid && cnt_out == '0 && tout == '0 && rnd == '0,
              "R1 reset during run", int'(osc_en), 0);
        stop_taps = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!osc_en && !valid, "R1 idle after reset", int'(valid), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule